// File: doc/BRIEF.md
# Code Bank Extension Unit

This unit widens a 16-bit processor address to a 20-bit physical address by placing a 4-bit bank number above it, giving sixteen 64 KB banks and 1 MB in total. It keeps one bank register for program code and a second one for external data. At any moment exactly one bank of each space is active.

Subroutine calls and returns change the code bank without software doing anything. A call strobe carries a target bank. On that call the unit saves the current code bank on a private stack and switches to the target. A return strobe takes the saved bank off the stack and makes it active again. The stack is a 128-entry RAM that only this logic can reach. Its pointer runs over the values 80h to FFh and rests at 7Fh when the stack is empty. A call moves the pointer up before it writes. A return reads first and then moves the pointer down.

The unit also tells the fetch path where each code fetch goes. When the external-access pin is high, addresses below a fixed internal limit go to internal memory and all higher addresses go to external memory. When the pin is low, every fetch goes to external memory.

Top module: `bank_ext_unit`

## Requirements
- R1: `code_phys_o` equals {`code_bank_o`, `code_addr_i`} and `data_phys_o` equals {`data_bank_o`, `data_addr_i`}, with the bank in bits 19:16.
- R2: After reset both banks are 0, both flags are 0 and the stack is empty (pointer 7Fh).
- R3: An accepted call makes `code_bank_o` equal to `call_bank_i` one cycle later. In the same cycle the unit pushes the previous code bank (pointer first incremented, then written).
- R4: An accepted return restores the bank pushed by the matching call, then decrements the pointer. Nested calls unwind in last-in, first-out order.
- R5: With `ext_access_i` = 1, `fetch_ext_o` is 0 (internal) when `code_phys_o` is below INT_LIMIT (default 0C000h) and 1 (external) otherwise.
- R6: With `ext_access_i` = 0, `fetch_ext_o` is 1 for every address.
- R7: A call made while the pointer is at FFh sets the sticky flag `ovf_o`. The pointer and the code bank stay unchanged.
- R8: A return made while the pointer is at 7Fh sets the sticky flag `unf_o`. The pointer and the code bank stay unchanged.
- R9: `data_bank_we_i` = 1 loads `data_bank_i` into the data bank on the next edge. Calls and returns never change the data bank.
- R10: When call and return are strobed in the same cycle, the call is performed and the return is ignored.
- R11: 128 nested calls all fit on the stack, and each one is restored correctly by its return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Call strobe, one cycle |
| ret_i | input | 1 | Return strobe, one cycle |
| call_bank_i | input | 4 | Target code bank for the call |
| data_bank_we_i | input | 1 | Load strobe for the data bank |
| data_bank_i | input | 4 | New data bank value |
| ext_access_i | input | 1 | External-access pin level |
| code_addr_i | input | 16 | Processor code address |
| data_addr_i | input | 16 | Processor external-data address |
| code_phys_o | output | 20 | Physical code address |
| data_phys_o | output | 20 | Physical data address |
| fetch_ext_o | output | 1 | 1 = fetch from external memory |
| code_bank_o | output | 4 | Active code bank |
| data_bank_o | output | 4 | Active data bank |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The bench fills the stack to exactly 128 entries, then attempts one call more. A pointer that is off by one would either raise overflow one call early or overwrite a saved bank, and the full unwind that follows would then return a wrong bank. A return on an empty stack, both at reset and after the full unwind, catches a design that decrements past 7Fh or loads stale RAM contents into the bank. The bench also strobes call and return together, which exposes a design where the return wins or both act. It probes addresses on each side of the internal limit and in a higher bank, which catches a compare that looks only at the 16-bit address.

// File: rtl/bx_pkg.sv
package bx_pkg;
   localparam int BX_ADDR_W = 16;
   localparam int BX_BANK_W = 4;
   localparam int BX_PTR_W  = 8;

   // Stack operation selected in a cycle
   typedef enum logic [1:0] {
      STK_IDLE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_HOLD = 2'd3   // request refused (overflow or underflow)
   } stk_op_e;
endpackage

// File: rtl/bx_stack_ptr.sv
module bx_stack_ptr
   import bx_pkg::*;
#(
   parameter int PTR_W     = BX_PTR_W,
   parameter int STK_DEPTH = 128,
   localparam int IDX_W    = $clog2(STK_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             call_i,
   input  logic             ret_i,
   output stk_op_e          op_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic [PTR_W-1:0] sp_o,
   output logic             ovf_o,
   output logic             unf_o
);
   localparam logic [PTR_W-1:0] PTR_TOP  = {PTR_W{1'b1}};
   localparam logic [PTR_W-1:0] PTR_BASE = PTR_W'((2 ** PTR_W) - STK_DEPTH);
   localparam logic [PTR_W-1:0] PTR_RST  = PTR_BASE - PTR_W'(1);

   if (STK_DEPTH < 2 || STK_DEPTH >= (2 ** PTR_W)) begin : g_bad_depth
      $error("bx_stack_ptr: STK_DEPTH must lie between 2 and 2**PTR_W-1");
   end
   if ((2 ** IDX_W) != STK_DEPTH) begin : g_bad_pow2
      $error("bx_stack_ptr: STK_DEPTH must be a power of two");
   end

   logic [PTR_W-1:0] sp_q;
   logic [PTR_W-1:0] sp_inc;
   logic [PTR_W-1:0] wr_off;
   logic [PTR_W-1:0] rd_off;

   assign sp_inc = sp_q + PTR_W'(1);
   assign wr_off = sp_inc - PTR_BASE;
   assign rd_off = sp_q - PTR_BASE;
   assign wr_idx_o = wr_off[IDX_W-1:0];
   assign rd_idx_o = rd_off[IDX_W-1:0];

   always_comb begin
      op_o = STK_IDLE;
      if (call_i) begin
         op_o = (sp_q == PTR_TOP) ? STK_HOLD : STK_PUSH;
      end else if (ret_i) begin
         op_o = (sp_q == PTR_RST) ? STK_HOLD : STK_POP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= PTR_RST;
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
      end else begin
         unique case (op_o)
            STK_PUSH: sp_q <= sp_inc;
            STK_POP:  sp_q <= sp_q - PTR_W'(1);
            STK_HOLD: begin
               if (call_i) ovf_o <= 1'b1;
               else        unf_o <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign sp_o = sp_q;
endmodule

// File: rtl/bx_stack_ram.sv
module bx_stack_ram #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 128,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [WIDTH-1:0] rd_data_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("bx_stack_ram: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[wr_idx_i] <= wr_data_i;
   end

   assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/bx_addr_map.sv
module bx_addr_map #(
   parameter int          ADDR_W    = 16,
   parameter int          BANK_W    = 4,
   parameter int unsigned INT_LIMIT = 'h0C000,
   parameter bit          HAS_SEL   = 1'b1,
   localparam int         PHYS_W    = ADDR_W + BANK_W
) (
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ext_access_i,
   output logic [PHYS_W-1:0] phys_o,
   output logic              ext_o
);
   if (PHYS_W > 31) begin : g_bad_phys
      $error("bx_addr_map: physical width too large for INT_LIMIT compare");
   end

   assign phys_o = {bank_i, addr_i};

   if (!HAS_SEL) begin : g_no_sel
      assign ext_o = 1'b1;
   end else if (INT_LIMIT == 0) begin : g_all_ext
      assign ext_o = 1'b1;
   end else begin : g_cmp
      localparam logic [PHYS_W:0] LIMIT = (PHYS_W + 1)'(INT_LIMIT);
      logic below;
      assign below = ({1'b0, phys_o} < LIMIT);
      assign ext_o = !ext_access_i || !below;
   end
endmodule

// File: rtl/bank_ext_unit.sv
module bank_ext_unit
   import bx_pkg::*;
#(
   parameter int          ADDR_W    = BX_ADDR_W,
   parameter int          BANK_W    = BX_BANK_W,
   parameter int          PTR_W     = BX_PTR_W,
   parameter int          STK_DEPTH = 128,
   parameter int unsigned INT_LIMIT = 'h0C000,
   localparam int         PHYS_W    = ADDR_W + BANK_W,
   localparam int         IDX_W     = $clog2(STK_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [BANK_W-1:0] call_bank_i,
   input  logic              data_bank_we_i,
   input  logic [BANK_W-1:0] data_bank_i,
   input  logic              ext_access_i,
   input  logic [ADDR_W-1:0] code_addr_i,
   input  logic [ADDR_W-1:0] data_addr_i,
   output logic [PHYS_W-1:0] code_phys_o,
   output logic [PHYS_W-1:0] data_phys_o,
   output logic              fetch_ext_o,
   output logic [BANK_W-1:0] code_bank_o,
   output logic [BANK_W-1:0] data_bank_o,
   output logic              ovf_o,
   output logic              unf_o
);
   stk_op_e          op;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic [PTR_W-1:0] sp;
   logic [BANK_W-1:0] saved_bank;
   logic [BANK_W-1:0] code_bank_q;
   logic [BANK_W-1:0] data_bank_q;
   logic              data_unused_ext;

   bx_stack_ptr #(.PTR_W(PTR_W), .STK_DEPTH(STK_DEPTH)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .call_i  (call_i),
      .ret_i   (ret_i),
      .op_o    (op),
      .wr_idx_o(wr_idx),
      .rd_idx_o(rd_idx),
      .sp_o    (sp),
      .ovf_o   (ovf_o),
      .unf_o   (unf_o)
   );

   bx_stack_ram #(.WIDTH(BANK_W), .DEPTH(STK_DEPTH)) u_ram (
      .clk      (clk),
      .we_i     (op == STK_PUSH),
      .wr_idx_i (wr_idx),
      .wr_data_i(code_bank_q),
      .rd_idx_i (rd_idx),
      .rd_data_o(saved_bank)
   );

   // Code bank: replaced by target on push, by stacked value on pop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_bank_q <= '0;
      end else begin
         unique case (op)
            STK_PUSH: code_bank_q <= call_bank_i;
            STK_POP:  code_bank_q <= saved_bank;
            default: ;
         endcase
      end
   end

   // Data bank: loaded only through its own strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              data_bank_q <= '0;
      else if (data_bank_we_i) data_bank_q <= data_bank_i;
   end

   bx_addr_map #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .INT_LIMIT(INT_LIMIT), .HAS_SEL(1'b1)
   ) u_code_map (
      .bank_i      (code_bank_q),
      .addr_i      (code_addr_i),
      .ext_access_i(ext_access_i),
      .phys_o      (code_phys_o),
      .ext_o       (fetch_ext_o)
   );

   bx_addr_map #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .INT_LIMIT(INT_LIMIT), .HAS_SEL(1'b0)
   ) u_data_map (
      .bank_i      (data_bank_q),
      .addr_i      (data_addr_i),
      .ext_access_i(ext_access_i),
      .phys_o      (data_phys_o),
      .ext_o       (data_unused_ext)
   );

   assign code_bank_o = code_bank_q;
   assign data_bank_o = data_bank_q;
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
   parameter int ADDR_W = 16,
   parameter int BANK_W = 4,
   parameter int PTR_W  = 8,
   parameter int STK_DEPTH = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_i,
   input logic              ret_i,
   input logic [BANK_W-1:0] call_bank_i,
   input logic              data_bank_we_i,
   input logic              ext_access_i,
   input logic              fetch_ext_o,
   input logic [BANK_W-1:0] code_bank_o,
   input logic [BANK_W-1:0] data_bank_o,
   input logic              ovf_o,
   input logic              unf_o,
   input logic [PTR_W-1:0]  sp
);
   localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};
   localparam logic [PTR_W-1:0] RST = PTR_W'((2 ** PTR_W) - STK_DEPTH - 1);

   assert_call_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && sp != TOP) |=> (code_bank_o == $past(call_bank_i) && sp == $past(sp) + PTR_W'(1)));

   assert_ret_pops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && sp != RST) |=> sp == $past(sp) - PTR_W'(1));

   assert_ext_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_access_i |-> fetch_ext_o);

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && sp == TOP) |=> (ovf_o && $stable(sp) && $stable(code_bank_o)));

   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && sp == RST) |=> (unf_o && $stable(sp) && $stable(code_bank_o)));

   assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |=> unf_o);

   assert_data_bank_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !data_bank_we_i |=> $stable(data_bank_o));

   assert_sp_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sp >= RST);
endmodule

bind bank_ext_unit bx_checker #(
   .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PTR_W(PTR_W), .STK_DEPTH(STK_DEPTH)
) u_bx_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .call_i        (call_i),
   .ret_i         (ret_i),
   .call_bank_i   (call_bank_i),
   .data_bank_we_i(data_bank_we_i),
   .ext_access_i  (ext_access_i),
   .fetch_ext_o   (fetch_ext_o),
   .code_bank_o   (code_bank_o),
   .data_bank_o   (data_bank_o),
   .ovf_o         (ovf_o),
   .unf_o         (unf_o),
   .sp            (sp)
);

// File: tb/bank_ext_unit_test.sv
`timescale 1ns/1ps
module bank_ext_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 1'b0, ret_i = 1'b0;
   logic [3:0]  call_bank_i = '0;
   logic        data_bank_we_i = 1'b0;
   logic [3:0]  data_bank_i = '0;
   logic        ext_access_i = 1'b1;
   logic [15:0] code_addr_i = '0, data_addr_i = '0;
   logic [19:0] code_phys_o, data_phys_o;
   logic        fetch_ext_o;
   logic [3:0]  code_bank_o, data_bank_o;
   logic        ovf_o, unf_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [3:0] model_stk [128];
   int         model_depth;

   always #2.5 clk = ~clk;

   bank_ext_unit uut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      call_i = 0; ret_i = 0; data_bank_we_i = 0;
      @(negedge clk);
      rst_n = 1'b1;
      model_depth = 0;
      @(negedge clk);
   endtask

   // Drive at a negedge, result visible at the next negedge
   task automatic do_call(input logic [3:0] b);
      call_i = 1'b1; call_bank_i = b;
      @(negedge clk);
      call_i = 1'b0;
   endtask

   task automatic do_ret();
      ret_i = 1'b1;
      @(negedge clk);
      ret_i = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R2 code bank", 32'(code_bank_o), 0);
      check("R2 data bank", 32'(data_bank_o), 0);
      check("R2 ovf", 32'(ovf_o), 0);
      check("R2 unf", 32'(unf_o), 0);
      do_ret();  // empty stack at reset
      check("R2 R8 unf on empty", 32'(unf_o), 1);
      check("R8 bank kept", 32'(code_bank_o), 0);
   endtask

   task automatic t_addr_map();
      do_reset();
      code_addr_i = 16'h1234; ext_access_i = 1'b1;
      #1;
      check("R1 code phys bank0", 32'(code_phys_o), 32'h01234);
      check("R5 internal below limit", 32'(fetch_ext_o), 0);
      code_addr_i = 16'hBFFF; #1;
      check("R5 internal at limit-1", 32'(fetch_ext_o), 0);
      code_addr_i = 16'hC000; #1;
      check("R5 external at limit", 32'(fetch_ext_o), 1);
      ext_access_i = 1'b0; code_addr_i = 16'h0010; #1;
      check("R6 forced external", 32'(fetch_ext_o), 1);
      ext_access_i = 1'b1;
      @(negedge clk);
      do_call(4'h1);
      code_addr_i = 16'h0004; #1;
      check("R1 code phys bank1", 32'(code_phys_o), 32'h10004);
      check("R5 bank1 low address is external", 32'(fetch_ext_o), 1);
      data_addr_i = 16'hABCD; #1;
      check("R1 data phys", 32'(data_phys_o), 32'h0ABCD);
      @(negedge clk);
   endtask

   task automatic t_nested();
      do_reset();
      do_call(4'h3);
      check("R3 first call target", 32'(code_bank_o), 3);
      do_call(4'h7);
      check("R3 second call target", 32'(code_bank_o), 7);
      do_call(4'hE);
      check("R3 third call target", 32'(code_bank_o), 14);
      do_ret();
      check("R4 pop to 7", 32'(code_bank_o), 7);
      do_ret();
      check("R4 pop to 3", 32'(code_bank_o), 3);
      do_ret();
      check("R4 pop to 0", 32'(code_bank_o), 0);
      check("R4 no underflow yet", 32'(unf_o), 0);
   endtask

   task automatic t_data_bank();
      do_reset();
      data_bank_we_i = 1'b1; data_bank_i = 4'h9;
      @(negedge clk);
      data_bank_we_i = 1'b0;
      check("R9 data bank loaded", 32'(data_bank_o), 9);
      do_call(4'h5);
      check("R9 call leaves data bank", 32'(data_bank_o), 9);
      do_ret();
      check("R9 return leaves data bank", 32'(data_bank_o), 9);
      check("R9 code bank back", 32'(code_bank_o), 0);
   endtask

   task automatic t_call_and_ret();
      do_reset();
      do_call(4'h2);
      call_i = 1'b1; ret_i = 1'b1; call_bank_i = 4'hB;
      @(negedge clk);
      call_i = 1'b0; ret_i = 1'b0;
      check("R10 call wins", 32'(code_bank_o), 11);
      do_ret();
      check("R10 return pops call", 32'(code_bank_o), 2);
      do_ret();
      check("R10 stack depth", 32'(code_bank_o), 0);
      check("R10 no underflow", 32'(unf_o), 0);
   endtask

   task automatic t_fill();
      logic [3:0] cur;
      do_reset();
      cur = 4'h0;
      for (int i = 0; i < 128; i++) begin
         logic [3:0] nb;
         nb = 4'((i * 7 + 5) % 16);
         model_stk[model_depth] = cur;
         model_depth++;
         do_call(nb);
         cur = nb;
      end
      check("R11 full stack no overflow", 32'(ovf_o), 0);
      check("R11 last target", 32'(code_bank_o), 32'(cur));
      do_call(cur ^ 4'hF);
      check("R7 overflow flag", 32'(ovf_o), 1);
      check("R7 bank unchanged", 32'(code_bank_o), 32'(cur));
      for (int i = 0; i < 128; i++) begin
         model_depth--;
         do_ret();
         if (code_bank_o !== model_stk[model_depth])
            check("R11 unwind", 32'(code_bank_o), 32'(model_stk[model_depth]));
      end
      check("R11 unwound to 0", 32'(code_bank_o), 0);
      check("R7 overflow sticky", 32'(ovf_o), 1);
      check("R8 not yet underflow", 32'(unf_o), 0);
      do_ret();
      check("R8 underflow after unwind", 32'(unf_o), 1);
      check("R8 bank unchanged", 32'(code_bank_o), 0);
      do_call(4'h6);
      check("R8 R3 call still works", 32'(code_bank_o), 6);
      check("R8 underflow sticky", 32'(unf_o), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_addr_map();
      t_nested();
      t_data_bank();
      t_call_and_ret();
      t_fill();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule